// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets an on-chip master read and write an external asynchronous static RAM of 128K bytes through a synchronous request/ready handshake. The master presents an address, a write flag and write data. The controller accepts the request when it is ready. It then runs the strobe sequence on the memory pins and, for a read, returns the byte with a one-cycle response pulse.

Every phase length is a count of clock cycles. Each count is computed at elaboration from a clock-period parameter and from the nanosecond limits of the memory's speed grade. A write is framed by chip enable low and write enable low, and the write ends when write enable rises. Output enable stays high for the whole write. Between a read and a write, in either order, the controller leaves the bus idle for one cycle.

States: IDLE (ready), TURN (bus turnaround), WSETUP (address and chip enable settle), WPULSE (write enable low), WHOLD (write enable high, data still driven), RACCESS (chip and output enable low, waiting out access time), RDONE (response pulse). Transitions:
- IDLE to WSETUP or RACCESS on accept.
- IDLE to TURN on accept when the direction differs from the previous operation.
- TURN to WSETUP or RACCESS.
- WSETUP to WPULSE.
- WPULSE to WHOLD when its timer expires.
- WHOLD to IDLE.
- RACCESS to RDONE when its timer expires.
- RDONE to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_ce_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the operation completes, and a write holds it low for WP+2 cycles (plus one for turnaround).
- R3: A write runs one setup cycle (chip enable low, write enable high), then WP cycles with write enable low, then one hold cycle with write enable high and chip enable low. The byte is stored at the requested address.
- R4: Output enable is high in every cycle where write enable is low, and the data drivers are off in every cycle where output enable is low.
- R5: Address and write data stay stable from the cycle write enable falls through the cycle after it rises. Chip enable is already low in the cycle before write enable falls. Data is driven from the write-enable fall through one cycle after it rises.
- R6: A read holds chip enable and output enable low for RD cycles. It registers mem_dq_in at the end of the last of those cycles and raises rsp_valid for exactly one cycle with that byte. req_ready is low for RD+1 cycles (plus one for turnaround).
- R7: A read that follows a write, or a write that follows a read, is preceded by one cycle with all strobes high and drivers off. No such cycle is inserted between two operations of the same direction, nor before the first operation after reset.
- R8: WP = ceil(max(tWP, tAW, tDS) / clock period) and RD = ceil(max(tAA, tOE, tRC) / clock period), each at least 1. With an 8 ns clock and the 10 ns grade, WP = 1 and RD = 2.
- R9: rsp_valid is asserted only for reads, once per read, and never for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W (8) | Read byte |
| mem_addr | output | ADDR_W (17) | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W (8) | Data toward memory, for the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W (8) | Data from the pad |

## Verification
The bench sweeps every address of a 10-bit configuration with writes, then with reads, then with alternating write/read pairs. Its memory model returns a junk byte until the access time has elapsed, so capturing one cycle early shows up as a data miscompare. Busy time is measured per operation: a missing or extra turnaround cycle, or a wrong pulse length, changes the count. The model also records the write pulse, so a short pulse or an early release of the drivers is reported. A turnaround wrongly added after reset or between same-direction operations is caught on the very first request.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_RDONE
    } ctrl_state_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 8,
    parameter int T_WP_NS = 8,
    parameter int T_AW_NS = 8,
    parameter int T_DS_NS = 6,
    parameter int T_AA_NS = 10,
    parameter int T_OE_NS = 5,
    parameter int T_RC_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned WP_CYC = ns_to_cyc(max3(T_WP_NS, T_AW_NS, T_DS_NS), CLK_NS);
    localparam int unsigned RD_CYC = ns_to_cyc(max3(T_AA_NS, T_OE_NS, T_RC_NS), CLK_NS);
    localparam int unsigned MAX_CYC = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);

    ctrl_state_e state_q, state_d;
    logic        accept;
    logic        wr_q;
    logic        last_vld_q, last_wr_q;
    logic        need_turn;
    logic        tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic        capture;

    assign accept    = req_valid && req_ready;
    assign need_turn = last_vld_q && (last_wr_q != req_write);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (need_turn)      state_d = ST_TURN;
                    else if (req_write) state_d = ST_WSETUP;
                    else                state_d = ST_RACCESS;
                end
            end
            ST_TURN:    state_d = wr_q ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  state_d = ST_WPULSE;
            ST_WPULSE:  state_d = tmr_expired ? ST_WHOLD : ST_WPULSE;
            ST_WHOLD:   state_d = ST_IDLE;
            ST_RACCESS: state_d = tmr_expired ? ST_RDONE : ST_RACCESS;
            ST_RDONE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered pin and handshake outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            req_ready <= 1'b1;
            rsp_valid <= 1'b0;
        end else begin
            mem_ce_n  <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACCESS});
            mem_we_n  <= (state_d != ST_WPULSE);
            mem_oe_n  <= (state_d != ST_RACCESS);
            mem_dq_oe <= (state_d inside {ST_WPULSE, ST_WHOLD});
            req_ready <= (state_d == ST_IDLE);
            rsp_valid <= (state_d == ST_RDONE);
        end
    end

    // request latch and direction history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            wr_q       <= 1'b0;
            last_vld_q <= 1'b0;
            last_wr_q  <= 1'b0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            wr_q       <= req_write;
            last_vld_q <= 1'b1;
            last_wr_q  <= req_write;
            if (req_write) mem_dq_out <= req_wdata;
        end
    end

    assign tmr_load = ((state_d == ST_WPULSE) && (state_q != ST_WPULSE)) ||
                      ((state_d == ST_RACCESS) && (state_q != ST_RACCESS));
    assign tmr_val  = (state_d == ST_WPULSE) ? WP_LOAD : RD_LOAD;
    assign capture  = (state_q == ST_RACCESS) && tmr_expired;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata)
    );

endmodule

// File: rtl/sram_async_ctrl_checker.sv
module sram_async_ctrl_checker #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);

    AST_HANDSHAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_WRITE_FRAMED_BY_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R3

    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R4

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R4

    AST_CE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr))); // R5

    AST_STABLE_AFTER_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe)); // R5

    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_RSP_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_we_n && mem_ce_n)); // R9

endmodule

bind sram_async_ctrl sram_async_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int CLK = 8;
    localparam int TWP = 8, TAW = 8, TDS = 6, TAA = 10, TOE = 5, TRC = 10;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int WP = cdiv(mx(mx(TWP, TAW), TDS));
    localparam int RD = cdiv(mx(mx(TAA, TOE), TRC));

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK / 2) clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK),
        .T_WP_NS(TWP), .T_AW_NS(TAW), .T_DS_NS(TDS),
        .T_AA_NS(TAA), .T_OE_NS(TOE), .T_RC_NS(TRC)
    ) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // memory model: returns junk until the access time has elapsed
    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    int acc = 0;
    logic [AW-1:0] acc_addr = '0;
    logic rd_act;
    assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = (rd_act && (acc * CLK >= TAA) && (acc_addr == mem_addr)) ? mdl[mem_addr] : 8'hA5;

    bit prev_ov = 0;
    int pulse = 0;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_act) begin
                if (acc == 0 || acc_addr != mem_addr) begin acc = 1; acc_addr = mem_addr; end
                else acc = acc + 1;
            end else acc = 0;
            if (mem_dq_oe && rd_act) begin
                fails++; $display("FAIL R4 contention: dq_oe=%0d oe_n=%0d expected dq_oe=0", mem_dq_oe, mem_oe_n);
            end
            if (!mem_ce_n && !mem_we_n) begin
                if (!prev_ov) begin pulse = 0; wa = mem_addr; wd = mem_dq_out; end
                pulse++;
                if (!mem_dq_oe || !mem_oe_n || mem_addr != wa || mem_dq_out != wd) begin
                    fails++; $display("FAIL R5 pulse: oe=%0d addr=%0h data=%0h expected oe=1 addr=%0h data=%0h",
                                      mem_dq_oe, mem_addr, mem_dq_out, wa, wd);
                end
                prev_ov = 1;
            end else if (prev_ov) begin
                if (!mem_dq_oe || mem_addr != wa || mem_dq_out != wd || mem_ce_n) begin
                    fails++; $display("FAIL R5 hold: oe=%0d ce_n=%0d data=%0h expected oe=1 ce_n=0 data=%0h",
                                      mem_dq_oe, mem_ce_n, mem_dq_out, wd);
                end
                if (pulse != WP) begin
                    fails++; $display("FAIL R3 pulse width: %0d expected %0d", pulse, WP);
                end
                mdl[wa] = wd;
                prev_ov = 0;
            end
        end
    end

    bit has_last = 0;
    bit last_wr = 0;

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        int rsp_cnt;
        int exp_busy;
        logic [DW-1:0] got;
        bit turn;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        turn = has_last && (last_wr != wr);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        req_wdata = ~d;
        req_addr  = ~a;
        if (wr) exp_mem[a] = d;
        n = 1; rsp_cnt = 0; got = '0;
        if (rsp_valid) begin rsp_cnt++; got = rsp_rdata; end
        while (!req_ready && n < 50) begin
            @(negedge clk);
            n++;
            if (rsp_valid) begin rsp_cnt++; got = rsp_rdata; end
        end
        n--;
        exp_busy = (wr ? WP + 2 : RD + 1) + (turn ? 1 : 0);
        vectors++;
        if (n != exp_busy) begin
            fails++; $display("FAIL R2/R7 busy cycles wr=%0d turn=%0d: %0d expected %0d", wr, turn, n, exp_busy);
        end
        vectors++;
        if (rsp_cnt != (wr ? 0 : 1)) begin
            fails++; $display("FAIL R9 rsp count wr=%0d: %0d expected %0d", wr, rsp_cnt, wr ? 0 : 1);
        end
        if (!wr) begin
            vectors++;
            if (got !== exp_mem[a]) begin
                fails++; $display("FAIL R6 read data at %0h: %0h expected %0h", a, got, exp_mem[a]);
            end
        end
        has_last = 1; last_wr = wr;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mdl[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (!(req_ready && !rsp_valid && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)) begin
            fails++; $display("FAIL R1 reset: rdy=%0d rsp=%0d ce=%0d we=%0d oe=%0d dq_oe=%0d expected 1 0 1 1 1 0",
                              req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe);
        end
        rst_n = 1;
        // R8: derived counts for the default grade
        vectors++;
        if (WP != 1 || RD != 2) begin
            fails++; $display("FAIL R8 counts: WP=%0d RD=%0d expected 1 2", WP, RD);
        end
        // R3 R7: write sweep, first op without turnaround
        for (int a = 0; a < DEPTH; a++) do_op(1'b1, AW'(a), DW'((a * 37 + 11) ^ (a >> 3)));
        // R6 R7: read sweep, one turnaround at the start
        for (int a = 0; a < DEPTH; a++) do_op(1'b0, AW'(a), '0);
        // R7: alternating directions
        for (int i = 0; i < 256; i++) begin
            do_op(1'b1, AW'(i * 3), DW'(255 - i));
            do_op(1'b0, AW'(DEPTH - 1 - i), '0);
            do_op(1'b0, AW'(i * 3), '0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule